// File: doc/BRIEF.md
# Wakeup-Select Issue Arbiter

This block sits beside a reservation-station window and chooses which waiting entries go to execution in each cycle. Wakeup (operand tag matching) is done elsewhere. The arbiter sees only the result of that step: a per-entry ready bit, a per-entry age stamped at dispatch, and a per-entry execution-unit class. For every execution unit it grants at most one entry per cycle and reports the grant both as a one-hot vector and as an encoded index. A ready entry whose unit is busy with an older entry keeps waiting. It holds up no entry of another unit.

The selection policy is fixed while reset is held, and there are three choices:
- **Global oldest-first.** Each unit picks the oldest ready entry of its class from the whole window.
- **Banked.** The window is cut into one equal bank per unit, and each unit picks the oldest ready entry in its own bank.
- **Head-only queue.** Each bank behaves as a circular queue and only its head slot may issue.

The owner of the window clears a granted entry's ready bit one cycle after the grant. Until then the arbiter masks that entry itself, so the same entry is never granted twice in a row.

Top module: `issue_select`

## Requirements
- R1: While rst_n is low every grant output, index and valid bit is zero, and after release nothing is granted while no entry is ready.
- R2: mode_i is captured only while rst_n is low: 0 selects global oldest-first, 1 banked, 2 head-only queue, 3 behaves as 0. Changes of mode_i after release have no effect on the grants.
- R3: In global mode, unit u grants the ready entry whose class_i field equals u and whose age_i field is smallest. If no ready entry has class u, unit u grants nothing, whatever the other units do.
- R4: Each unit's slice grant_o[u*ENTRIES +: ENTRIES] is one-hot or zero, and no entry is granted by two units. grant_vld_o[u] is set exactly when the slice is non-zero, and grant_idx_o[u*IDX_W +: IDX_W] holds the granted entry number, or zero when there is no grant.
- R5: An entry granted in one cycle is not granted in the next cycle even if its ready bit is still set. It may be granted again from the cycle after that.
- R6: In banked mode, unit u considers only entries u*BANK to u*BANK+BANK-1 (BANK = ENTRIES/UNITS) and grants the ready one with the smallest age. class_i is ignored.
- R7: In head-only mode, unit u may grant only entry u*BANK+head, where head is 0 after reset and advances by one, wrapping at BANK, after each grant by that unit. A ready entry that is not at the head is never granted.
- R8: Only entries whose ready bit is set in the current cycle are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also captures mode_i |
| mode_i | input | 2 | Selection policy, sampled during reset |
| ready_i | input | ENTRIES | Per-entry woken-up flag |
| age_i | input | ENTRIES*AGE_W | Per-entry dispatch age, smaller is older, entry e at [e*AGE_W +: AGE_W] |
| class_i | input | ENTRIES*CLS_W | Per-entry execution-unit class, entry e at [e*CLS_W +: CLS_W] |
| grant_o | output | UNITS*ENTRIES | One-hot grant per unit, unit u at [u*ENTRIES +: ENTRIES] |
| grant_idx_o | output | UNITS*IDX_W | Granted entry number per unit |
| grant_vld_o | output | UNITS | Unit u has a grant this cycle |

## Verification
The block keeps only three pieces of state: the captured mode, the one-cycle grant mask and the per-bank head pointers. A fault in any of them reaches the grant outputs within one or two cycles.
- A mode captured wrongly changes which entries are eligible on the first cycle that has mixed classes and banks.
- A mask that is stuck or never cleared drops or repeats a grant on the very next cycle.
- A head pointer that advances wrongly moves the head-only grant to the wrong slot at the following grant.

The sweeps feed every ready pattern in each mode, with ages and classes that change from step to step. A single wrong state therefore appears as a mismatch within a few steps.

// File: rtl/issue_select.sv
module issue_select #(
  parameter int ENTRIES = 8,
  parameter int UNITS   = 2,
  parameter int AGE_W   = 4,
  localparam int CLS_W  = (UNITS > 1) ? $clog2(UNITS) : 1,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_i,
  input  logic [ENTRIES-1:0]       ready_i,
  input  logic [ENTRIES*AGE_W-1:0] age_i,
  input  logic [ENTRIES*CLS_W-1:0] class_i,
  output logic [UNITS*ENTRIES-1:0] grant_o,
  output logic [UNITS*IDX_W-1:0]   grant_idx_o,
  output logic [UNITS-1:0]         grant_vld_o
);
  localparam int BANK   = ENTRIES / UNITS;
  localparam int BIDX_W = (BANK > 1) ? $clog2(BANK) : 1;
  localparam logic [1:0] MODE_BANK = 2'd1;
  localparam logic [1:0] MODE_FIFO = 2'd2;

  logic [1:0]              mode_q;
  logic [ENTRIES-1:0]      last_q;
  logic [ENTRIES-1:0]      grant_any;
  logic [UNITS*BIDX_W-1:0] head_q;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [ENTRIES-1:0] cand;
    logic               found;
    logic [IDX_W-1:0]   best;
    logic [AGE_W-1:0]   best_age;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      localparam int BANK_ID = e / BANK;
      localparam int SLOT    = e % BANK;
      logic in_scope;
      always_comb begin
        case (mode_q)
          MODE_BANK: in_scope = (BANK_ID == u);
          MODE_FIFO: in_scope = (BANK_ID == u) &&
                                (head_q[u*BIDX_W +: BIDX_W] == BIDX_W'(SLOT));
          default:   in_scope = (class_i[e*CLS_W +: CLS_W] == CLS_W'(u));
        endcase
      end
      assign cand[e] = rst_n & ready_i[e] & ~last_q[e] & in_scope;
    end

    always_comb begin
      found    = 1'b0;
      best     = '0;
      best_age = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (cand[e] && (!found || age_i[e*AGE_W +: AGE_W] < best_age)) begin
          found    = 1'b1;
          best     = IDX_W'(e);
          best_age = age_i[e*AGE_W +: AGE_W];
        end
      end
    end

    assign grant_o[u*ENTRIES +: ENTRIES] = found ? (ENTRIES'(1) << best) : '0;
    assign grant_idx_o[u*IDX_W +: IDX_W] = best;
    assign grant_vld_o[u]                = found;
  end

  always_comb begin
    grant_any = '0;
    for (int u = 0; u < UNITS; u++) grant_any |= grant_o[u*ENTRIES +: ENTRIES];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= mode_i;
      last_q <= '0;
      head_q <= '0;
    end else begin
      last_q <= grant_any;
      if (mode_q == MODE_FIFO) begin
        for (int u = 0; u < UNITS; u++) begin
          if (grant_vld_o[u]) begin
            if (head_q[u*BIDX_W +: BIDX_W] == BIDX_W'(BANK - 1))
              head_q[u*BIDX_W +: BIDX_W] <= '0;
            else
              head_q[u*BIDX_W +: BIDX_W] <= head_q[u*BIDX_W +: BIDX_W] + 1'b1;
          end
        end
      end
    end
  end
endmodule

module issue_select_chk #(
  parameter int ENTRIES = 8,
  parameter int UNITS   = 2,
  parameter int CLS_W   = 1,
  parameter int IDX_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               mode_q,
  input logic [ENTRIES-1:0]       ready_i,
  input logic [ENTRIES*CLS_W-1:0] class_i,
  input logic [UNITS*ENTRIES-1:0] grant_o,
  input logic [UNITS*IDX_W-1:0]   grant_idx_o,
  input logic [UNITS-1:0]         grant_vld_o
);
  localparam int BANK = ENTRIES / UNITS;
  logic [ENTRIES-1:0] any_g;

  always_comb begin
    any_g = '0;
    for (int u = 0; u < UNITS; u++) any_g |= grant_o[u*ENTRIES +: ENTRIES];
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (grant_o == '0 && grant_vld_o == '0)); // R1
  AST_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n) (any_g & ~ready_i) == '0); // R8
  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n) (any_g & $past(any_g)) == '0); // R5
  AST_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n) $countones(grant_o) == $countones(any_g)); // R4

  for (genvar u = 0; u < UNITS; u++) begin : g_chk
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_o[u*ENTRIES +: ENTRIES])); // R4
    AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n) grant_vld_o[u] |-> grant_o[u*ENTRIES + int'(grant_idx_o[u*IDX_W +: IDX_W])]); // R4
    AST_CLASS_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (grant_vld_o[u] && (mode_q == 2'd0 || mode_q == 2'd3)) |-> (class_i[int'(grant_idx_o[u*IDX_W +: IDX_W])*CLS_W +: CLS_W] == CLS_W'(u))); // R3
    AST_BANK_SCOPE: assert property (@(posedge clk) disable iff (!rst_n) (grant_vld_o[u] && (mode_q == 2'd1 || mode_q == 2'd2)) |-> (int'(grant_idx_o[u*IDX_W +: IDX_W]) / BANK == u)); // R6
  end
endmodule

bind issue_select issue_select_chk #(
  .ENTRIES(ENTRIES), .UNITS(UNITS), .CLS_W(CLS_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .ready_i(ready_i), .class_i(class_i),
  .grant_o(grant_o), .grant_idx_o(grant_idx_o), .grant_vld_o(grant_vld_o)
);

// File: tb/tb_issue_select.sv
module tb_issue_select;
  localparam int E = 8;
  localparam int U = 2;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [E-1:0]  ready_i = '0;
  logic [E*AW-1:0] age_i = '0;
  logic [E-1:0]  class_i = '0;
  logic [U*E-1:0] grant_o;
  logic [U*3-1:0] grant_idx_o;
  logic [U-1:0]  grant_vld_o;

  int checks = 0;
  int fails = 0;
  int m_mode = 0;
  logic [E-1:0] m_last = '0;
  int m_head[U];
  int age[E];
  int cls[E];

  issue_select #(.ENTRIES(E), .UNITS(U), .AGE_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ready_i(ready_i), .age_i(age_i),
    .class_i(class_i), .grant_o(grant_o), .grant_idx_o(grant_idx_o), .grant_vld_o(grant_vld_o)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, got hung, expected completion");
    finish_run();
  end

  task automatic set_inputs(input int pat, input logic [E-1:0] rdy);
    for (int e = 0; e < E; e++) begin
      age[e] = (e * 3 + pat * 7) & 15;
      cls[e] = ((pat * 5) >> e) & 1;
      age_i[e*AW +: AW] = AW'(age[e]);
      class_i[e] = cls[e][0];
    end
    ready_i = rdy;
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0;
    mode_i = m;
    set_inputs(0, '1);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (grant_o != '0 || grant_vld_o != '0 || grant_idx_o != '0) begin
      fails++;
      $display("FAIL R1: grants during reset got %h/%b expected 0", grant_o, grant_vld_o);
    end
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mode_i = ~m;
    m_mode = (m == 2'd3) ? 0 : int'(m);
    m_last = '0;
    for (int u = 0; u < U; u++) m_head[u] = 0;
  endtask

  task automatic step(input int pat, input logic [E-1:0] rdy, input string tag);
    logic [E-1:0] any_exp;
    set_inputs(pat, rdy);
    #2;
    any_exp = '0;
    for (int u = 0; u < U; u++) begin
      int best;
      logic [E-1:0] exp_g;
      best = -1;
      for (int e = 0; e < E; e++) begin
        bit ok;
        if (m_mode == 1) ok = (e / 4 == u);
        else if (m_mode == 2) ok = (e == u * 4 + m_head[u]);
        else ok = (cls[e] == u);
        ok = ok && rdy[e] && !m_last[e];
        if (ok && (best < 0 || age[e] < age[best])) best = e;
      end
      exp_g = (best < 0) ? '0 : (E'(1) << best);
      any_exp |= exp_g;
      checks++;
      if (grant_o[u*E +: E] != exp_g || grant_vld_o[u] != (best >= 0) ||
          int'(grant_idx_o[u*3 +: 3]) != ((best < 0) ? 0 : best)) begin
        fails++;
        $display("FAIL %s: pat %0d unit %0d got grant %b idx %0d vld %b expected grant %b idx %0d vld %b",
                 tag, pat, u, grant_o[u*E +: E], grant_idx_o[u*3 +: 3], grant_vld_o[u],
                 exp_g, (best < 0) ? 0 : best, best >= 0);
      end
    end
    @(posedge clk);
    m_last = any_exp;
    if (m_mode == 2)
      for (int u = 0; u < U; u++)
        if (any_exp[u*4 +: 4] != '0) m_head[u] = (m_head[u] + 1) % 4;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R1 reset and idle, global mode
    do_reset(2'd0);
    step(0, 8'h00, "R1");
    // R5 same ready set held: oldest, then next, then oldest again
    step(1, 8'hFF, "R5");
    step(1, 8'hFF, "R5");
    step(1, 8'hFF, "R5");
    step(1, 8'hFF, "R5");
    // R3 and R8 global sweep over every ready pattern
    for (int p = 0; p < 256; p++) step(p, E'(p), "R3");
    // R2 code 3 acts as global
    do_reset(2'd3);
    for (int p = 0; p < 64; p++) step(p * 3, E'(p * 3), "R2");
    // R6 banked, mode_i changed after release must not matter (R2)
    do_reset(2'd1);
    for (int p = 0; p < 256; p++) step(p, E'(p), "R6");
    // R7 head-only queue
    do_reset(2'd2);
    for (int p = 0; p < 16; p++) step(p, 8'hFF, "R7");
    for (int p = 0; p < 256; p++) step(p, E'(p), "R7");
    for (int p = 0; p < 8; p++) step(p, 8'hEE, "R7");
    finish_run();
  end
endmodule